// File: doc/BRIEF.md
# Transactional Line Buffer with Conflict Tracking

This block is a small direct-mapped line buffer placed beside one core that runs transactions. The core issues begin, commit and abort commands, and loads and stores with a word address. While a transaction is open, every line the core reads or writes is tagged with a read mark or a write mark. Speculative store data stays inside the buffer and is hidden from other agents. Snooped reads and writes from other agents are checked against these marks. A snoop that clashes with them ends the transaction at once, and every speculatively written line is dropped.

Commit turns the speculative lines into ordinary dirty lines in one cycle, and from then on snoops can see them. Outside a transaction the buffer is write-through. A dirty line is written to memory before it is evicted, and before a transaction first overwrites it, so that memory always holds the value from before the transaction. Line fills come from the memory beside the buffer through a line-wide fill input that is sampled in the same cycle.

Top module: `txbuf_top`

## Requirements
- R1: After reset, no transaction is open, no abort is reported, rdValid and memWrValid are low, and the buffer holds no lines, so a first load returns the memory line through fillLine.
- R2: Command codes on opCode are begin 0, commit 1, abort 2, load 3 and store 4. Commit and abort outside a transaction do nothing. A begin inside a transaction is ignored and the transaction stays open.
- R3: A load in a transaction marks its line as read. A later snooped write to that line aborts the transaction with cause 3.
- R4: A store in a transaction marks its line as written and keeps the data local. A snooped read of that line sees snpHit low and aborts with cause 2.
- R5: A snooped write to a line marked as written aborts with cause 3.
- R6: A snooped read of a line that is only marked as read does not abort. A snoop to a line that is not resident does not abort.
- R7: Conflicts are found per line, where a line is two words selected by address bit 0. A snoop to the other word of a marked line still aborts.
- R8: Commit closes the transaction without an abort, and in the next cycle a snooped read returns the committed data with snpHit high.
- R9: An explicit abort reports cause 1. After it, lines written in the transaction are gone, memory is unchanged, and a load returns the value from before the transaction.
- R10: A transactional access that misses, on an index whose resident line carries a mark, aborts with cause 4. The access is not performed and returns no data.
- R11: A store outside a transaction drives memWrValid in the next cycle with the merged line. On a hit it also updates the buffer. On a miss it allocates nothing.
- R12: A dirty line is written to memory in the cycle after it is evicted, or after a transaction first stores to it.
- R13: When a conflicting snoop and a commit arrive in the same cycle, the abort wins: the cause is the snoop's, and the speculative data is discarded.
- R14: A performed load raises rdValid in the next cycle with the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Core command or access valid |
| opCode | input | 3 | 0 begin, 1 commit, 2 abort, 3 load, 4 store |
| opAddr | input | ADDR_W | Word address of the access |
| opData | input | DATA_W | Store data |
| fillLine | input | LINE_W | Memory content of the line at opAddr |
| rdValid | output | 1 | Load data valid, one cycle after the load |
| rdData | output | DATA_W | Loaded word |
| snpValid | input | 1 | Snoop request valid |
| snpWrite | input | 1 | Snoop is a write (1) or a read (0) |
| snpAddr | input | ADDR_W | Snooped word address |
| snpHit | output | 1 | Snoop read finds visible data (same cycle) |
| snpData | output | LINE_W | Line returned to the snooper |
| memWrValid | output | 1 | Line write to memory |
| memWrAddr | output | ADDR_W-OFF_W | Line address of the write |
| memWrData | output | LINE_W | Line data of the write |
| txActive | output | 1 | Transaction open |
| abortValid | output | 1 | Abort pulse |
| abortCause | output | 3 | 0 none, 1 explicit, 2 snoop read, 3 snoop write, 4 capacity |

## Verification
A snooped request and a core command can land in the same cycle. The case that matters is a conflicting snoop read arriving together with commit. The bench opens a transaction, stores to a line, and then drives commit and a snoop read of that line on the same edge. It expects an abort with the snoop-read cause, txActive low, and a following load that returns the memory value and not the stored word. Snoops that arrive next to loads and stores in the table are judged in the same way, from the abort pulse and the cause.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  typedef enum logic [2:0] {
    OP_BEGIN  = 3'd0,
    OP_COMMIT = 3'd1,
    OP_ABORT  = 3'd2,
    OP_LOAD   = 3'd3,
    OP_STORE  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_CMD   = 3'd1,
    CAUSE_SNPRD = 3'd2,
    CAUSE_SNPWR = 3'd3,
    CAUSE_CAP   = 3'd4
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;      // install tag and line at opIdx
    logic writeLine;  // store merged word into line
    logic setR;       // set read mark
    logic setW;       // set write mark
    logic rdLoad;     // return load word
    logic wbVictim;   // write resident dirty victim to memory
    logic wbHit;      // write resident dirty line before speculation
    logic storeThru;  // non-transactional write-through
    logic commit;     // marks to plain state
    logic abort;      // drop written lines, clear marks
    logic snpInval;   // snooped write drops local copy
  } strobe_t;

endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       snpValid,
  input  logic       snpWrite,
  input  logic       coreHit,
  input  logic       hitDirty,
  input  logic       victimTracked,
  input  logic       victimDirty,
  input  logic       snpMatch,
  input  logic       snpRd,
  input  logic       snpWr,
  output strobe_t    strb,
  output logic       txActive,
  output logic       abortValid,
  output logic [2:0] abortCause
);

  logic inTx;
  logic isBegin, isCommit, isAbort, isLoad, isStore, memAcc;
  logic conflict, capAbort, cmdAbort, commitNow, accessGo, abortNow;
  cause_e causeNow;

  always_comb begin
    isBegin  = opValid && (opCode == OP_BEGIN);
    isCommit = opValid && (opCode == OP_COMMIT);
    isAbort  = opValid && (opCode == OP_ABORT);
    isLoad   = opValid && (opCode == OP_LOAD);
    isStore  = opValid && (opCode == OP_STORE);
    memAcc   = isLoad || isStore;

    // snooped read vs write mark, snooped write vs either mark
    conflict  = inTx && snpValid && ((!snpWrite && snpWr) || (snpWrite && (snpRd || snpWr)));
    capAbort  = inTx && memAcc && !coreHit && victimTracked && !conflict;
    cmdAbort  = inTx && isAbort && !conflict;
    commitNow = inTx && isCommit && !conflict;
    accessGo  = memAcc && !conflict && !capAbort;
    abortNow  = conflict || capAbort || cmdAbort;

    if (conflict)      causeNow = snpWrite ? CAUSE_SNPWR : CAUSE_SNPRD;
    else if (capAbort) causeNow = CAUSE_CAP;
    else if (cmdAbort) causeNow = CAUSE_CMD;
    else               causeNow = CAUSE_NONE;

    strb.abort     = abortNow;
    strb.commit    = commitNow;
    strb.rdLoad    = accessGo && isLoad;
    strb.alloc     = accessGo && !coreHit && (isLoad || inTx);
    strb.wbVictim  = accessGo && !coreHit && (isLoad || inTx) && victimDirty;
    strb.writeLine = accessGo && isStore && (inTx || coreHit);
    strb.setR      = accessGo && isLoad && inTx;
    strb.setW      = accessGo && isStore && inTx;
    strb.wbHit     = accessGo && isStore && inTx && hitDirty;
    strb.storeThru = accessGo && isStore && !inTx;
    strb.snpInval  = snpValid && snpWrite && snpMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inTx       <= 1'b0;
      abortValid <= 1'b0;
      abortCause <= CAUSE_NONE;
    end else begin
      if (abortNow || commitNow) inTx <= 1'b0;
      else if (isBegin)          inTx <= 1'b1;
      abortValid <= abortNow;
      abortCause <= causeNow;
    end
  end

  assign txActive = inTx;

  // an abort pulse always coincides with a closed transaction
  assert_abort_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> !txActive);

  // a reported abort carries a real cause
  assert_cause_known_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> (abortCause != CAUSE_NONE && abortCause <= CAUSE_CAP));

  // no cause without a pulse
  assert_cause_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !abortValid |-> (abortCause == CAUSE_NONE));

endmodule

// File: rtl/txbuf_data.sv
module txbuf_data
  import txbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 16,
  localparam int LINES  = 1 << IDX_W,
  localparam int WORDS  = 1 << OFF_W,
  localparam int LINE_W = DATA_W * WORDS,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int LA_W   = ADDR_W - OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  strobe_t           strb,
  input  logic              txActive,
  output logic              coreHit,
  output logic              hitDirty,
  output logic              victimTracked,
  output logic              victimDirty,
  output logic              snpMatch,
  output logic              snpRd,
  output logic              snpWr,
  output logic              snpHit,
  output logic [LINE_W-1:0] snpData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memWrValid,
  output logic [LA_W-1:0]   memWrAddr,
  output logic [LINE_W-1:0] memWrData
);

  logic [LINES-1:0]  vld, rBit, wBit, dirty;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINE_W-1:0] dataMem [LINES];

  logic [IDX_W-1:0]  opIdx, sIdx;
  logic [TAG_W-1:0]  opTag, sTag;
  logic [OFF_W-1:0]  opWord;
  logic [LINE_W-1:0] baseLine, newLine;
  logic              resident;

  always_comb begin
    opIdx  = opAddr[OFF_W +: IDX_W];
    opTag  = opAddr[ADDR_W-1 -: TAG_W];
    opWord = opAddr[OFF_W-1:0];
    sIdx   = snpAddr[OFF_W +: IDX_W];
    sTag   = snpAddr[ADDR_W-1 -: TAG_W];

    coreHit       = vld[opIdx] && (tagMem[opIdx] == opTag);
    resident      = vld[opIdx] && !coreHit;
    hitDirty      = coreHit && dirty[opIdx];
    victimTracked = resident && (rBit[opIdx] || wBit[opIdx]);
    victimDirty   = resident && dirty[opIdx];

    snpMatch = snpValid && vld[sIdx] && (tagMem[sIdx] == sTag);
    snpRd    = snpMatch && rBit[sIdx];
    snpWr    = snpMatch && wBit[sIdx];
    snpHit   = snpMatch && !wBit[sIdx];
    snpData  = dataMem[sIdx];

    baseLine = coreHit ? dataMem[opIdx] : fillLine;
    newLine  = baseLine;
    newLine[int'(opWord)*DATA_W +: DATA_W] = opData;
  end

  // state bits with reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld        <= '0;
      rBit       <= '0;
      wBit       <= '0;
      dirty      <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
    end else begin
      rdValid    <= strb.rdLoad;
      rdData     <= baseLine[int'(opWord)*DATA_W +: DATA_W];
      memWrValid <= strb.wbVictim || strb.wbHit || strb.storeThru;
      memWrAddr  <= strb.storeThru ? opAddr[ADDR_W-1:OFF_W] : {tagMem[opIdx], opIdx};
      memWrData  <= strb.storeThru ? newLine : dataMem[opIdx];

      if (strb.commit) begin
        dirty <= dirty | wBit;
        rBit  <= '0;
        wBit  <= '0;
      end
      if (strb.abort) begin
        vld  <= vld & ~wBit;
        rBit <= '0;
        wBit <= '0;
      end
      if (strb.snpInval) vld[sIdx] <= 1'b0;
      if (strb.alloc) begin
        vld[opIdx]   <= 1'b1;
        dirty[opIdx] <= 1'b0;
        rBit[opIdx]  <= 1'b0;
        wBit[opIdx]  <= 1'b0;
      end
      if (strb.setR) rBit[opIdx] <= 1'b1;
      if (strb.setW) wBit[opIdx] <= 1'b1;
      if (strb.wbHit || strb.storeThru) dirty[opIdx] <= 1'b0;
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (strb.alloc) tagMem[opIdx] <= opTag;
    if (strb.alloc || strb.writeLine)
      dataMem[opIdx] <= strb.writeLine ? newLine : fillLine;
  end

  // marks only live on resident lines
  assert_marks_resident_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((rBit | wBit) & ~vld) == '0);

  // no marks survive outside a transaction
  assert_marks_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> (rBit == '0 && wBit == '0));

  // a speculative line never hides a dirty pre-transaction value
  assert_spec_not_dirty_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wBit & dirty) == '0);

  // at most one memory write source per cycle
  assert_one_memwr_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wbVictim, strb.wbHit, strb.storeThru}));

  // an aborting cycle never writes line data
  assert_abort_no_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |-> !(strb.writeLine || strb.alloc));

endmodule

// File: rtl/txbuf_top.sv
module txbuf_top
  import txbuf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 16,
  localparam int LINE_W = DATA_W * (1 << OFF_W),
  localparam int LA_W   = ADDR_W - OFF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [LINE_W-1:0] fillLine,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic [LINE_W-1:0] snpData,
  output logic              memWrValid,
  output logic [LA_W-1:0]   memWrAddr,
  output logic [LINE_W-1:0] memWrData,
  output logic              txActive,
  output logic              abortValid,
  output logic [2:0]        abortCause
);

  strobe_t strb;
  logic coreHit, hitDirty, victimTracked, victimDirty;
  logic snpMatch, snpRd, snpWr;

  txbuf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .snpValid(snpValid), .snpWrite(snpWrite),
    .coreHit(coreHit), .hitDirty(hitDirty), .victimTracked(victimTracked),
    .victimDirty(victimDirty), .snpMatch(snpMatch), .snpRd(snpRd), .snpWr(snpWr),
    .strb(strb), .txActive(txActive), .abortValid(abortValid), .abortCause(abortCause)
  );

  txbuf_data #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .opAddr(opAddr), .opData(opData), .fillLine(fillLine),
    .snpValid(snpValid), .snpAddr(snpAddr), .strb(strb), .txActive(txActive),
    .coreHit(coreHit), .hitDirty(hitDirty), .victimTracked(victimTracked),
    .victimDirty(victimDirty), .snpMatch(snpMatch), .snpRd(snpRd), .snpWr(snpWr),
    .snpHit(snpHit), .snpData(snpData), .rdValid(rdValid), .rdData(rdData),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

endmodule

// File: tb/sim_txbuf_top.sv
`timescale 1ns/1ps
module sim_txbuf_top;

  localparam int NVEC = 20;
  localparam logic [2:0] NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [7:0]  opAddr = 8'h0;
  logic [15:0] opData = 16'h0;
  logic [31:0] fillLine;
  logic        rdValid;
  logic [15:0] rdData;
  logic        snpValid = 1'b0;
  logic        snpWrite = 1'b0;
  logic [7:0]  snpAddr = 8'h0;
  logic        snpHit;
  logic [31:0] snpData;
  logic        memWrValid;
  logic [6:0]  memWrAddr;
  logic [31:0] memWrData;
  logic        txActive;
  logic        abortValid;
  logic [2:0]  abortCause;

  int checks = 0;
  int errors = 0;
  logic [31:0] memModel [128];
  logic [31:0] saved;

  always #10 clk = ~clk;

  txbuf_top u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opAddr(opAddr),
    .opData(opData), .fillLine(fillLine), .rdValid(rdValid), .rdData(rdData),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpAddr(snpAddr), .snpHit(snpHit),
    .snpData(snpData), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .txActive(txActive), .abortValid(abortValid),
    .abortCause(abortCause)
  );

  // memory scoreboard: fills come from it, line writes update it
  assign fillLine = memModel[opAddr[7:1]];
  always @(negedge clk) if (rstN && memWrValid) memModel[memWrAddr] = memWrData;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [15:0] data;
    logic        sV;
    logic        sW;
    logic [7:0]  sAddr;
    logic        expAb;
    logic [2:0]  expCause;
    logic        expTx;
  } vec_t;

  localparam vec_t TABLE [NVEC] = '{
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1}, // begin
    '{3'd3, 8'h10, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1}, // load line 8
    '{3'd4, 8'h22, 16'hBEEF, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1}, // store line 0x11
    '{NOP,  8'h00, 16'h0000, 1'b1, 1'b0, 8'h11, 1'b0, 3'd0, 1'b1}, // R6 snoop rd on read mark
    '{NOP,  8'h00, 16'h0000, 1'b1, 1'b1, 8'h11, 1'b1, 3'd3, 1'b0}, // R3 R7 other word
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{3'd4, 8'h22, 16'h1234, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{NOP,  8'h00, 16'h0000, 1'b1, 1'b0, 8'h23, 1'b1, 3'd2, 1'b0}, // R4 R7
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{3'd4, 8'h22, 16'h5678, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{NOP,  8'h00, 16'h0000, 1'b1, 1'b1, 8'h22, 1'b1, 3'd3, 1'b0}, // R5
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{3'd3, 8'h30, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{NOP,  8'h00, 16'h0000, 1'b1, 1'b1, 8'h40, 1'b0, 3'd0, 1'b1}, // R6 non-resident
    '{3'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0}, // R8 commit
    '{3'd1, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0}, // R2 stray commit
    '{3'd2, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0}, // R2 stray abort
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1},
    '{3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1}, // R2 nested begin
    '{3'd2, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0}  // R9 explicit
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    opValid = (op != NOP);
    opCode  = (op == NOP) ? 3'd0 : op;
    opAddr  = a;
    opData  = d;
  endtask

  task automatic setSnp(input logic v, input logic w, input logic [7:0] a);
    snpValid = v; snpWrite = w; snpAddr = a;
  endtask

  task automatic tick();
    @(posedge clk); #2;
    setOp(NOP, 8'h0, 16'h0);
    setSnp(1'b0, 1'b0, 8'h0);
  endtask

  task automatic doOp(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    setOp(op, a, d);
    tick();
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    for (int i = 0; i < 128; i++) memModel[i] = 32'(i) * 32'h00010001 + 32'hC0015000;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    // R1 reset state
    chk(!txActive && !abortValid && !rdValid && !memWrValid, "R1 reset", {28'h0, txActive, abortValid, rdValid, memWrValid}, 32'h0);
    doOp(3'd3, 8'h50, 16'h0);
    chk(rdValid && rdData == memModel[8'h28][15:0], "R1 R14 first load", {15'h0, rdValid, rdData}, {16'h1, memModel[8'h28][15:0]});

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      setOp(TABLE[k].op, TABLE[k].addr, TABLE[k].data);
      setSnp(TABLE[k].sV, TABLE[k].sW, TABLE[k].sAddr);
      tick();
      chk(abortValid == TABLE[k].expAb && abortCause == TABLE[k].expCause && txActive == TABLE[k].expTx,
          $sformatf("R2-table vector %0d", k), {27'h0, abortValid, abortCause, txActive},
          {27'h0, TABLE[k].expAb, TABLE[k].expCause, TABLE[k].expTx});
    end

    // R4 hidden, R8 commit visibility, R12 eviction
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd4, 8'h06, 16'hCAFE);
    setSnp(1'b1, 1'b0, 8'h07); #1;
    chk(!snpHit, "R4 speculative hidden", {31'h0, snpHit}, 32'h0);
    setSnp(1'b0, 1'b0, 8'h0);
    doOp(3'd1, 8'h0, 16'h0);
    chk(!abortValid && !txActive, "R8 commit clean", {30'h0, abortValid, txActive}, 32'h0);
    setSnp(1'b1, 1'b0, 8'h07); #1;
    chk(snpHit && snpData[15:0] == 16'hCAFE, "R8 committed visible", {snpHit, 15'h0, snpData[15:0]}, {1'b1, 15'h0, 16'hCAFE});
    tick();
    chk(!abortValid, "R8 snoop after commit", {31'h0, abortValid}, 32'h0);
    saved = memModel[3];
    doOp(3'd3, 8'h0E, 16'h0);
    chk(memWrValid && memWrAddr == 7'd3 && memWrData == {saved[31:16], 16'hCAFE}, "R12 dirty eviction",
        memWrData, {saved[31:16], 16'hCAFE});
    #10;
    chk(memModel[3][15:0] == 16'hCAFE, "R12 scoreboard", memModel[3], {saved[31:16], 16'hCAFE});

    // R9 abort leaves memory unchanged
    saved = memModel[5];
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd4, 8'h0A, 16'hDEAD);
    doOp(3'd2, 8'h0, 16'h0);
    chk(abortValid && abortCause == 3'd1, "R9 cause", {29'h0, abortCause}, 32'd1);
    doOp(3'd3, 8'h0A, 16'h0);
    chk(rdData == saved[15:0] && memModel[5] == saved, "R9 restored", {16'h0, rdData}, {16'h0, saved[15:0]});

    // R10 capacity
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd3, 8'h10, 16'h0);
    doOp(3'd3, 8'h30, 16'h0);
    chk(abortValid && abortCause == 3'd4 && !txActive && !rdValid, "R10 capacity",
        {27'h0, abortValid, abortCause, rdValid}, {27'h0, 1'b1, 3'd4, 1'b0});

    // R11 write-through
    saved = memModel[5];
    doOp(3'd4, 8'h0A, 16'h7777);
    chk(memWrValid && memWrAddr == 7'd5 && memWrData == {saved[31:16], 16'h7777}, "R11 hit through",
        memWrData, {saved[31:16], 16'h7777});
    doOp(3'd3, 8'h0A, 16'h0);
    chk(rdValid && rdData == 16'h7777, "R11 hit updates", {16'h0, rdData}, 32'h7777);
    saved = memModel[8'h30];
    doOp(3'd4, 8'h60, 16'h4444);
    chk(memWrValid && memWrAddr == 7'h30 && memWrData == {saved[31:16], 16'h4444}, "R11 miss through",
        memWrData, {saved[31:16], 16'h4444});
    setSnp(1'b1, 1'b0, 8'h60); #1;
    chk(!snpHit, "R11 no allocate", {31'h0, snpHit}, 32'h0);
    tick();

    // R12 first speculative store to a dirty line
    saved = memModel[6];
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd4, 8'h0C, 16'hAAAA);
    doOp(3'd1, 8'h0, 16'h0);
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd4, 8'h0C, 16'hBBBB);
    chk(memWrValid && memWrAddr == 7'd6 && memWrData == {saved[31:16], 16'hAAAA}, "R12 pre-store writeback",
        memWrData, {saved[31:16], 16'hAAAA});
    doOp(3'd2, 8'h0, 16'h0);
    doOp(3'd3, 8'h0C, 16'h0);
    chk(rdData == 16'hAAAA, "R9 R12 committed value kept", {16'h0, rdData}, 32'hAAAA);

    // R13 commit and conflicting snoop on one edge
    saved = memModel[9];
    doOp(3'd0, 8'h0, 16'h0);
    doOp(3'd4, 8'h12, 16'h9999);
    setOp(3'd1, 8'h0, 16'h0);
    setSnp(1'b1, 1'b0, 8'h12);
    tick();
    chk(abortValid && abortCause == 3'd2 && !txActive, "R13 abort wins",
        {27'h0, abortValid, abortCause, txActive}, {27'h0, 1'b1, 3'd2, 1'b0});
    doOp(3'd3, 8'h12, 16'h0);
    chk(rdValid && rdData == saved[15:0], "R13 data discarded", {16'h0, rdData}, {16'h0, saved[15:0]});

    finish();
  end

endmodule